// File: doc/BRIEF.md
# Receive Destination Address Filter with Loadable Match Table

This block decides whether a received frame is meant for this station by looking at its 48-bit destination address. It applies three mode switches in a fixed priority order: accept any individual address, accept any group address, accept the all-ones address. When none of them applies, it compares the address against a table of exact-match entries. Each entry in the table can be switched on or off through an enable mask. Next to the accept decision it reports whether the frame was taken as multicast or as broadcast.

The match table is filled by a load sequencer. A single command starts it with a descriptor count and a byte pointer. It then walks a list of descriptors in memory through a simple word-read port with a fixed one-cycle read latency. After the last address descriptor it reads one more word, which becomes the enable mask, and it raises a sticky done flag. While the device is held in its reset mode, software can read back any table entry through an entry selector.

The address byte that arrives first on the wire sits in `req_addr[7:0]`, and its bit 0 is the group bit. The remaining bytes follow upward in order, so the last byte sits in `req_addr[47:40]`.

Top module: `addr_filter_cam`

## Requirements
- R1: After reset, `load_busy`, `load_done`, `res_valid` and `mem_rd` are 0, and the enable mask is all zero, so no table entry can match.
- R2: With `promisc_en` set, a request whose group bit `req_addr[0]` is 0 is accepted with both class flags at 0. A group address gets no benefit from `promisc_en`.
- R3: With `allmc_en` set, a request whose group bit is 1 is accepted with `res_mcast`=1 and `res_bcast`=0.
- R4: With `bcast_en` set, a request whose 48 bits are all ones is accepted with `res_bcast`=1. The multicast rule has priority: when `allmc_en` is also set, the flags are `res_mcast`=1 and `res_bcast`=0. A class flag is never raised without accept.
- R5: When no mode rule applies, a request is accepted with both flags at 0 if it equals a table entry whose enable-mask bit is set.
- R6: A request that no mode rule takes and that matches no enabled entry is rejected. An entry whose mask bit is 0 never matches.
- R7: A load walks descriptors while the low 5 bits of its count are nonzero. Each descriptor holds four 16-bit words at byte offsets 0, 2, 4 and 6 from the pointer. Word 0 is skipped. Words 1, 2 and 3 become entry bits [15:0], [31:16] and [47:32], which places the low byte first. Entries fill from index 0 upward, the count decrements by one per descriptor, and the pointer advances by 8 bytes. Count bits above bit 4 are ignored.
- R8: After the last address descriptor, word 0 of the next descriptor becomes the 16-bit enable mask, where bit i enables entry i. A load with count 0 replaces only the mask.
- R9: `load_busy` rises the cycle after a load command is taken in the idle state and stays high until the cycle in which `load_done` sets. `load_done` is cleared when a command is taken. A command issued while busy is ignored.
- R10: With `in_reset`=1, `rd_data` shows the table entry selected by `rd_ptr`. With `in_reset`=0, `rd_data` is 0.
- R11: A filter request made while `load_busy` is high is rejected with both flags at 0.
- R12: Each request cycle with `req_valid` high produces exactly one `res_valid` pulse on the next cycle. `res_accept` and the flags are 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_start | input | 1 | Load-table command pulse |
| load_count | input | 16 | Descriptor count; only bits [4:0] are used |
| load_base | input | ADDR_W (16) | Byte address of the first descriptor |
| mem_rd | output | 1 | Word read request |
| mem_addr | output | ADDR_W (16) | Byte address of the requested word |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Sticky load-complete flag |
| in_reset | input | 1 | Device reset mode; gates table readback |
| rd_ptr | input | IDX_W (4) | Entry selected for readback |
| rd_data | output | 48 | Selected entry, or 0 outside reset mode |
| req_valid | input | 1 | Filter request strobe |
| req_addr | input | 48 | Destination address, first wire byte in [7:0] |
| promisc_en | input | 1 | Accept every individual address |
| allmc_en | input | 1 | Accept every group address |
| bcast_en | input | 1 | Accept the all-ones address |
| res_valid | output | 1 | Filter result strobe |
| res_accept | output | 1 | Frame accepted |
| res_mcast | output | 1 | Accepted as multicast |
| res_bcast | output | 1 | Accepted as broadcast |

## Verification
The properties assume that the memory model returns data exactly one cycle after a read request. They also assume that the mode inputs and `req_addr` stay steady for the cycle in which `req_valid` is sampled. The bench drives every input on the falling edge, including the mode bits, and its memory returns data on the rising edge after `mem_rd`, which keeps the stimulus inside those assumptions. Load commands are issued both from the idle state and while a load is running, so the ignore path is exercised too.

// File: rtl/afc_pkg.sv
// Package: shared constants and types for the destination address filter.
// Assumes a 16-bit memory word and a 48-bit station address.
package afc_pkg;
    localparam int WORD_W   = 16;
    localparam int MAC_W    = 48;
    localparam int CNT_BITS = 5;
    localparam int DESC_WORDS = 4;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_EVAL,
        LD_REQ,
        LD_CAP
    } ld_state_t;

    typedef struct packed {
        logic accept;
        logic mcast;
        logic bcast;
    } filt_res_t;
endpackage

// File: rtl/cam_store.sv
// Module: cam_store
// Holds the exact-match address table and its enable mask, compares a key
// against every enabled entry in parallel and provides a readback port.
// Assumes at most one write source (the loader) per cycle.
module cam_store
    import afc_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [MAC_W-1:0]     wr_data,
    input  logic                 mask_wr,
    input  logic [N_ENTRIES-1:0] mask_data,
    input  logic [MAC_W-1:0]     key,
    output logic                 hit,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [MAC_W-1:0]     rd_entry
);
    logic [MAC_W-1:0]     ent_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] mask_q;
    logic [N_ENTRIES-1:0] match;

    // Table storage: one entry written per loader beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) ent_q[i] <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end

    // Enable mask register, written once at the end of each load.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_data;
    end

    // Parallel comparators, one per entry.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign match[g] = mask_q[g] && (ent_q[g] == key);
    end

    assign hit      = |match;
    assign rd_entry = ent_q[rd_idx];
endmodule

// File: rtl/cam_loader.sv
// Module: cam_loader
// Walks a descriptor list in memory and writes table entries, then the
// enable mask. Assumes read data arrives exactly one cycle after mem_rd.
module cam_loader
    import afc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int N_ENTRIES = 16,
    localparam int IDX_W      = $clog2(N_ENTRIES),
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [15:0]          count,
    input  logic [ADDR_W-1:0]    base,
    output logic                 mem_rd,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [MAC_W-1:0]     wr_data,
    output logic                 mask_wr,
    output logic [N_ENTRIES-1:0] mask_data,
    output logic                 busy,
    output logic                 done
);
    ld_state_t            state_q;
    logic [CNT_BITS-1:0]  cnt_q;
    logic [ADDR_W-1:0]    ptr_q;
    logic [IDX_W-1:0]     idx_q;
    logic [1:0]           widx_q;
    logic                 mask_phase_q;
    logic [2*WORD_W-1:0]  acc_q;
    logic                 done_q;

    // Sequencer: evaluate count, request a word, capture it, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= LD_IDLE;
            cnt_q        <= '0;
            ptr_q        <= '0;
            idx_q        <= '0;
            widx_q       <= '0;
            mask_phase_q <= 1'b0;
            acc_q        <= '0;
            done_q       <= 1'b0;
        end else begin
            case (state_q)
                LD_IDLE: begin
                    if (start) begin
                        cnt_q   <= count[CNT_BITS-1:0];
                        ptr_q   <= base;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                        state_q <= LD_EVAL;
                    end
                end
                LD_EVAL: begin
                    mask_phase_q <= (cnt_q == '0);
                    widx_q       <= (cnt_q == '0) ? 2'd0 : 2'd1;
                    state_q      <= LD_REQ;
                end
                LD_REQ: begin
                    state_q <= LD_CAP;
                end
                default: begin
                    if (mask_phase_q) begin
                        done_q  <= 1'b1;
                        state_q <= LD_IDLE;
                    end else if (widx_q == 2'd3) begin
                        cnt_q   <= cnt_q - 1'b1;
                        ptr_q   <= ptr_q + ADDR_W'(DESC_BYTES);
                        idx_q   <= idx_q + 1'b1;
                        state_q <= LD_EVAL;
                    end else begin
                        if (widx_q == 2'd1) acc_q[WORD_W-1:0]        <= mem_rdata;
                        else                acc_q[2*WORD_W-1:WORD_W] <= mem_rdata;
                        widx_q  <= widx_q + 1'b1;
                        state_q <= LD_REQ;
                    end
                end
            endcase
        end
    end

    assign mem_rd    = (state_q == LD_REQ);
    assign mem_addr  = ptr_q + (ADDR_W'(widx_q) * ADDR_W'(WORD_BYTES));
    assign wr_en     = (state_q == LD_CAP) && !mask_phase_q && (widx_q == 2'd3);
    assign wr_idx    = idx_q;
    assign wr_data   = {mem_rdata, acc_q};
    assign mask_wr   = (state_q == LD_CAP) && mask_phase_q;
    assign mask_data = mem_rdata[N_ENTRIES-1:0];
    assign busy      = (state_q != LD_IDLE);
    assign done      = done_q;
endmodule

// File: rtl/mode_filter.sv
// Module: mode_filter
// Applies the mode rules in fixed priority ahead of the table match and
// registers the result. Assumes mode inputs are steady with req_valid.
module mode_filter
    import afc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [MAC_W-1:0] key,
    input  logic             promisc_en,
    input  logic             allmc_en,
    input  logic             bcast_en,
    input  logic             cam_hit,
    input  logic             blocked,
    output logic             res_valid,
    output filt_res_t        res
);
    filt_res_t nxt;

    // Priority decision: individual, group, all-ones, then table.
    always_comb begin
        nxt = '0;
        if (!blocked) begin
            if (promisc_en && !key[0]) begin
                nxt.accept = 1'b1;
            end else if (allmc_en && key[0]) begin
                nxt.accept = 1'b1;
                nxt.mcast  = 1'b1;
            end else if (bcast_en && (&key)) begin
                nxt.accept = 1'b1;
                nxt.bcast  = 1'b1;
            end else if (cam_hit) begin
                nxt.accept = 1'b1;
            end
        end
    end

    // Result register: one pulse per request, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= req_valid;
            res       <= req_valid ? nxt : '0;
        end
    end
endmodule

// File: rtl/addr_filter_cam.sv
// Module: addr_filter_cam
// Top of the destination address filter: loader, table and mode filter.
// Assumes a word-read memory with one-cycle latency.
module addr_filter_cam
    import afc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic [15:0]       load_count,
    input  logic [ADDR_W-1:0] load_base,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              load_busy,
    output logic              load_done,
    input  logic              in_reset,
    input  logic [IDX_W-1:0]  rd_ptr,
    output logic [47:0]       rd_data,
    input  logic              req_valid,
    input  logic [47:0]       req_addr,
    input  logic              promisc_en,
    input  logic              allmc_en,
    input  logic              bcast_en,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_mcast,
    output logic              res_bcast
);
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    logic [MAC_W-1:0]     wr_data;
    logic                 mask_wr;
    logic [N_ENTRIES-1:0] mask_data;
    logic                 cam_hit;
    logic [MAC_W-1:0]     rd_entry;
    filt_res_t            res;

    cam_loader #(.ADDR_W(ADDR_W), .N_ENTRIES(N_ENTRIES)) u_loader (
        .clk(clk), .rst_n(rst_n), .start(load_start), .count(load_count),
        .base(load_base), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .mask_wr(mask_wr), .mask_data(mask_data),
        .busy(load_busy), .done(load_done)
    );

    cam_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .mask_wr(mask_wr), .mask_data(mask_data),
        .key(req_addr), .hit(cam_hit), .rd_idx(rd_ptr), .rd_entry(rd_entry)
    );

    mode_filter u_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .key(req_addr),
        .promisc_en(promisc_en), .allmc_en(allmc_en), .bcast_en(bcast_en),
        .cam_hit(cam_hit), .blocked(load_busy), .res_valid(res_valid),
        .res(res)
    );

    assign rd_data    = in_reset ? rd_entry : '0;
    assign res_accept = res.accept;
    assign res_mcast  = res.mcast;
    assign res_bcast  = res.bcast;
endmodule

// File: rtl/addr_filter_cam_chk.sv
// Module: addr_filter_cam_chk
// Temporal checks on the filter's ports, bound to the top module.
module addr_filter_cam_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_start,
    input logic              mem_rd,
    input logic              load_busy,
    input logic              load_done,
    input logic              in_reset,
    input logic [47:0]       rd_data,
    input logic              req_valid,
    input logic [47:0]       req_addr,
    input logic              promisc_en,
    input logic              allmc_en,
    input logic              res_valid,
    input logic              res_accept,
    input logic              res_mcast,
    input logic              res_bcast
);
    assert_busy_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_busy) |-> load_done);
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_start && !load_busy) |=> (load_busy && !load_done));
    assert_read_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> load_busy);
    assert_one_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_accept && !res_mcast && !res_bcast));
    assert_flag_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_mcast || res_bcast) |-> (res_accept && !(res_mcast && res_bcast)));
    assert_reject_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && load_busy) |=> !res_accept);
    assert_promisc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !load_busy && promisc_en && !req_addr[0])
        |=> (res_accept && !res_mcast && !res_bcast));
    assert_allmc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !load_busy && allmc_en && req_addr[0])
        |=> (res_accept && res_mcast && !res_bcast));
    assert_readback_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |-> (rd_data == 48'h0));
endmodule

bind addr_filter_cam addr_filter_cam_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/addr_filter_cam_bench.sv
// Directed bench for addr_filter_cam; one task per scenario.
module addr_filter_cam_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_start = 1'b0;
    logic [15:0] load_count = '0;
    logic [15:0] load_base = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        load_busy, load_done;
    logic        in_reset = 1'b0;
    logic [3:0]  rd_ptr = '0;
    logic [47:0] rd_data;
    logic        req_valid = 1'b0;
    logic [47:0] req_addr = '0;
    logic        promisc_en = 1'b0, allmc_en = 1'b0, bcast_en = 1'b0;
    logic        res_valid, res_accept, res_mcast, res_bcast;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [0:255];

    localparam logic [47:0] MAC0 = 48'h5544_3322_1100;
    localparam logic [47:0] MAC1 = 48'hBBAA_9988_7766;
    localparam logic [47:0] MAC2 = 48'h0F0E_0D0C_0B0A;
    localparam logic [47:0] MAC3 = 48'h7A79_7877_7674;

    always #5 clk = ~clk;

    addr_filter_cam u_addr_filter_cam (.*);

    // Memory model: one-cycle read latency, word addressed by byte address.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[8:1]];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Place an address descriptor; word 0 holds a marker that must be skipped.
    task automatic put_desc(input int base, input int n, input logic [47:0] mac);
        int w = base / 2 + n * 4;
        mem[w]     = 16'hDEAD;
        mem[w + 1] = mac[15:0];
        mem[w + 2] = mac[31:16];
        mem[w + 3] = mac[47:32];
    endtask

    task automatic start_load(input int base, input logic [15:0] cnt);
        @(negedge clk);
        load_base  = 16'(base);
        load_count = cnt;
        load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!load_done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(load_done && !load_busy, req, {62'd0, load_done, load_busy}, 64'h2);
    endtask

    task automatic filt(input logic [47:0] a, input logic p, input logic m, input logic b,
                        input logic ea, input logic em, input logic eb, input string req);
        @(negedge clk);
        req_addr = a; promisc_en = p; allmc_en = m; bcast_en = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(res_valid && res_accept == ea && res_mcast == em && res_bcast == eb, req,
            {60'd0, res_valid, res_accept, res_mcast, res_bcast}, {60'd0, 1'b1, ea, em, eb});
    endtask

    task automatic readback(input int idx, input logic rst_mode, input logic [47:0] exp, input string req);
        @(negedge clk);
        in_reset = rst_mode;
        rd_ptr = 4'(idx);
        #1;
        chk(rd_data == exp, req, {16'd0, rd_data}, {16'd0, exp});
        in_reset = 1'b0;
    endtask

    // R1: state right after reset; empty mask lets nothing through the table.
    task automatic t_reset;
        @(negedge clk);
        chk(!load_busy && !load_done && !res_valid && !mem_rd, "R1 idle after reset",
            {60'd0, load_busy, load_done, res_valid, mem_rd}, 64'h0);
        filt(48'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 R6 zero key vs disabled table");
    endtask

    // R7 R8 R9 R11: load three entries with mask 0x0005, reject a request mid-load.
    task automatic t_load;
        put_desc(32'h20, 0, MAC0);
        put_desc(32'h20, 1, MAC1);
        put_desc(32'h20, 2, MAC2);
        mem[(32'h20 + 3 * 8) / 2] = 16'h0005;
        start_load(32'h20, 16'd3);
        chk(load_busy && !load_done, "R9 busy after command", {62'd0, load_busy, load_done}, 64'h2);
        filt(48'h0000_0000_0002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 request during load");
        wait_done("R9 load completes");
        readback(0, 1'b1, MAC0, "R7 entry 0 byte order");
        readback(1, 1'b1, MAC1, "R7 entry 1 pointer step");
        readback(2, 1'b1, MAC2, "R7 entry 2");
        readback(2, 1'b0, 48'h0, "R10 readback outside reset");
        filt(MAC0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 R8 enabled entry 0 matches");
        filt(MAC2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 R8 enabled entry 2 matches");
        filt(MAC1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 disabled entry 1 rejected");
        filt(MAC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 unknown address rejected");
    endtask

    // R2 R3 R4: mode rules and their priority.
    task automatic t_modes;
        filt(MAC3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 promiscuous individual");
        filt(48'h0000_0000_0033, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 promiscuous ignores group");
        filt(48'h0000_005E_0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3 all multicast");
        filt(48'h0000_005E_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 group without mode");
        filt({48{1'b1}}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4 broadcast");
        filt({48{1'b1}}, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R4 multicast beats broadcast");
        filt({48{1'b1}}, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 broadcast off");
    endtask

    // R9: a second command while busy is ignored; done is cleared by a new load.
    task automatic t_busy_ignore;
        put_desc(32'h80, 0, MAC3);
        mem[(32'h80 + 8) / 2] = 16'h0001;
        mem[32'hC0 / 2] = 16'hFFFF;
        start_load(32'h80, 16'd1);
        chk(!load_done, "R9 done cleared by command", {63'd0, load_done}, 64'h0);
        start_load(32'hC0, 16'd0);
        wait_done("R9 first load completes");
        readback(0, 1'b1, MAC3, "R9 ignored command left entry 0");
        filt(MAC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 mask from first load only");
        filt(MAC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 new entry 0 matches");
    endtask

    // R7 R8: count whose low 5 bits are zero reloads only the mask.
    task automatic t_count_zero;
        mem[32'h100 / 2] = 16'h0006;
        start_load(32'h100, 16'h0020);
        wait_done("R8 mask-only load completes");
        readback(1, 1'b1, MAC1, "R7 high count bits ignored, entry 1 kept");
        filt(MAC1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 mask now enables entry 1");
        filt(MAC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 mask now disables entry 0");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_load;
        t_modes;
        t_busy_ignore;
        t_count_zero;
        repeat (2) @(negedge clk);
        summary;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary;
    end
endmodule